// File: doc/BRIEF.md
# Processor Reset Watcher with Deep-Sleep Gate

This block sits between the application processor's reset indication and the security controller's power and TPM logic. It brings the asynchronous, active-low reset line into the local clock domain and filters out short glitches. From the filtered line it derives a single-cycle TPM-reset request each time the processor enters reset. When the boot straps select the level reset style, it also raises a flag that allows deep sleep once the line has stayed low past a programmable hold time. A line held low that long means the processor will restart from its reset vector.

The straps are sampled once, in the first clock after reset is released, into a properties word. That word records the host bus (SPI or I2C) and the reset style. When the reset-style straps are contradictory or missing, the block flags them as invalid and stays passive. An active debug connection always vetoes deep sleep. The sleep permission is withdrawn as soon as the synchronized line returns high, without waiting for the glitch filter.

Top module: `soc_rst_monitor`

## Requirements
- R1: One clock after `rst_ni` is released, `props_o` holds the captured straps: bit 0 = `strap_spi_i` (1 = SPI, 0 = I2C), bit 5 = `strap_pulse_i` (pulse reset style), bit 6 = `strap_level_i` (level reset style), and all other bits are 0. Later strap changes have no effect on `props_o` until the next reset.
- R2: When the captured reset-style bits are both 1 or both 0, `strap_bad_o` is 1, and neither `tpm_rst_req_o` nor `deep_sleep_ok_o` ever asserts.
- R3: A low on `rst_line_i` that lasts fewer than `DEBOUNCE_CYCLES` synchronized samples causes no TPM-reset request.
- R4: With a valid style, each low on `rst_line_i` that survives the debounce produces exactly one `tpm_rst_req_o` pulse, one cycle wide, in both pulse and level styles.
- R5: In level style, with debug inactive, `deep_sleep_ok_o` asserts once the filtered line has been low for `LOW_HOLD_CYCLES` cycles, and it stays low for any shorter low.
- R6: In pulse style, `deep_sleep_ok_o` never asserts, however long the line stays low.
- R7: `deep_sleep_ok_o` is 0 in every cycle in which `dbg_active_i` is 1.
- R8: `deep_sleep_ok_o` returns to 0 within `SYNC_STAGES` + 1 cycles after `rst_line_i` goes high, without the debounce delay.
- R9: While `rst_ni` is low, `props_o` = 0, `strap_bad_o` = 1, and `tpm_rst_req_o` = `deep_sleep_ok_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_line_i | input | 1 | Processor reset indication, active low, asynchronous |
| strap_pulse_i | input | 1 | Strap: pulse reset style |
| strap_level_i | input | 1 | Strap: level reset style |
| strap_spi_i | input | 1 | Strap: 1 = SPI host bus, 0 = I2C |
| dbg_active_i | input | 1 | Debug connection active; vetoes deep sleep |
| tpm_rst_req_o | output | 1 | One-cycle TPM-reset request |
| deep_sleep_ok_o | output | 1 | Deep sleep permitted |
| strap_bad_o | output | 1 | Reset-style straps invalid |
| props_o | output | 8 | Captured properties word |

## Verification
The bench builds the block with `SYNC_STAGES` = 2, `DEBOUNCE_CYCLES` = 4 and `LOW_HOLD_CYCLES` = 40, in place of the one-second default. With these values, glitches of one or two cycles, short lows of 8 to 25 cycles, and lows of 60 to 90 cycles fall clearly on each side of both thresholds. The hold-time expiry, the veto by a debug connection during a long low, and the fast clearing after release can then all be reached in a few thousand cycles. All four strap combinations are applied through separate resets, so the invalid-strap path and the pulse-style sleep block are both covered.

// File: rtl/soc_rst_pkg.sv
package soc_rst_pkg;
  localparam int PROPS_W        = 8;
  localparam int PROP_SPI_BIT   = 0;
  localparam int PROP_PULSE_BIT = 5;
  localparam int PROP_LEVEL_BIT = 6;

  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_PULSE = 2'b01,
    MODE_LEVEL = 2'b10,
    MODE_BOTH  = 2'b11
  } rst_mode_e;

  function automatic rst_mode_e mode_of(input logic pulse, input logic level);
    return rst_mode_e'({level, pulse});
  endfunction

  function automatic logic mode_ok(input rst_mode_e m);
    return (m == MODE_PULSE) || (m == MODE_LEVEL);
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;  // idle level is high
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_debounce.sv
module rst_debounce #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic filt_o,
  output logic fell_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic          filt_q, fell_q;
  logic [CW-1:0] cnt_q;
  logic          flip;

  assign flip = (d_i != filt_q) && (cnt_q == CW'(CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
      fell_q <= 1'b0;
    end else begin
      fell_q <= flip && !d_i;
      if (d_i == filt_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        filt_q <= d_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;
  assign fell_o = fell_q;
endmodule

// File: rtl/low_timer.sv
module low_timer #(
  parameter int LIMIT = 24_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!low_i)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;  // saturate
  end

  assign expired_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/strap_latch.sv
module strap_latch
  import soc_rst_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pulse_i,
  input  logic               level_i,
  input  logic               spi_i,
  output logic [PROPS_W-1:0] props_o,
  output rst_mode_e          mode_o
);
  logic               taken_q;
  logic [PROPS_W-1:0] props_q;
  logic [PROPS_W-1:0] props_d;

  always_comb begin
    props_d                 = '0;
    props_d[PROP_SPI_BIT]   = spi_i;
    props_d[PROP_PULSE_BIT] = pulse_i;
    props_d[PROP_LEVEL_BIT] = level_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      props_q <= '0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      props_q <= props_d;
    end
  end

  assign props_o = props_q;
  assign mode_o  = mode_of(props_q[PROP_PULSE_BIT], props_q[PROP_LEVEL_BIT]);
endmodule

// File: rtl/soc_rst_monitor.sv
module soc_rst_monitor
  import soc_rst_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int LOW_HOLD_CYCLES = 24_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_line_i,
  input  logic               strap_pulse_i,
  input  logic               strap_level_i,
  input  logic               strap_spi_i,
  input  logic               dbg_active_i,
  output logic               tpm_rst_req_o,
  output logic               deep_sleep_ok_o,
  output logic               strap_bad_o,
  output logic [PROPS_W-1:0] props_o
);
  logic      line_sync, line_filt, line_fell, low_expired, req_q;
  rst_mode_e mode;

  rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_line_i),
    .q_o   (line_sync)
  );

  rst_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_sync),
    .filt_o(line_filt),
    .fell_o(line_fell)
  );

  low_timer #(.LIMIT(LOW_HOLD_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .low_i    (!line_filt),
    .expired_o(low_expired)
  );

  strap_latch u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(strap_pulse_i),
    .level_i(strap_level_i),
    .spi_i  (strap_spi_i),
    .props_o(props_o),
    .mode_o (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= line_fell && mode_ok(mode);
  end

  assign tpm_rst_req_o = req_q;
  assign strap_bad_o   = !mode_ok(mode);
  // release clears on the synchronized line, not the filtered one
  assign deep_sleep_ok_o = low_expired && (mode == MODE_LEVEL) &&
                           !dbg_active_i && !line_sync;
endmodule

// File: rtl/soc_rst_monitor_chk.sv
module soc_rst_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_sync_i,
  input logic       line_filt_i,
  input logic       dbg_active_i,
  input logic       tpm_rst_req_o,
  input logic       deep_sleep_ok_o,
  input logic       strap_bad_o,
  input logic [7:0] props_o
);
  p_props_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (props_o != 8'h00) |=> $stable(props_o));

  p_bad_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_bad_o |-> (!tpm_rst_req_o && !deep_sleep_ok_o));

  p_req_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpm_rst_req_o |=> !tpm_rst_req_o);

  p_req_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpm_rst_req_o |-> !line_filt_i);

  p_sleep_needs_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_sleep_ok_o |-> !line_filt_i);

  p_no_sleep_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    props_o[5] && !props_o[6] |-> !deep_sleep_ok_o);

  p_no_sleep_dbg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_active_i |-> !deep_sleep_ok_o);

  p_wake_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_sync_i && $past(line_sync_i)) |-> !deep_sleep_ok_o);

  always_comb begin
    if (!rst_ni) begin
      p_reset_idle_r9: assert (!tpm_rst_req_o && !deep_sleep_ok_o);
    end
  end
endmodule

bind soc_rst_monitor soc_rst_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .line_sync_i    (line_sync),
  .line_filt_i    (line_filt),
  .dbg_active_i   (dbg_active_i),
  .tpm_rst_req_o  (tpm_rst_req_o),
  .deep_sleep_ok_o(deep_sleep_ok_o),
  .strap_bad_o    (strap_bad_o),
  .props_o        (props_o)
);

// File: tb/soc_rst_monitor_tb.sv
`timescale 1ns/1ps
module soc_rst_monitor_tb;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int HOLD = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1, s_pulse = 1'b0, s_level = 1'b0, s_spi = 1'b0, dbg = 1'b0;
  logic       req, deep, bad;
  logic [7:0] props;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  soc_rst_monitor #(.SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB), .LOW_HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rst_line_i(line),
    .strap_pulse_i(s_pulse), .strap_level_i(s_level), .strap_spi_i(s_spi),
    .dbg_active_i(dbg), .tpm_rst_req_o(req), .deep_sleep_ok_o(deep),
    .strap_bad_o(bad), .props_o(props)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_props(input logic p, input logic l, input logic s);
    return {1'b0, l, p, 4'b0000, s};
  endfunction

  function automatic bit style_ok(input logic p, input logic l);
    return p != l;
  endfunction

  task automatic do_reset(input logic p, input logic l, input logic s);
    @(negedge clk);
    rst_n = 1'b0; line = 1'b1; dbg = 1'b0;
    s_pulse = p; s_level = l; s_spi = s;
    @(negedge clk);
    check(props == 8'h00 && bad && !req && !deep, "R9", {props, bad, req, deep}, 11'h004);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(props == exp_props(p, l, s), "R1", props, exp_props(p, l, s));
    check(bad == !style_ok(p, l), "R2", bad, !style_ok(p, l));
  endtask

  // drive one low of len cycles, then high for gap cycles
  task automatic low_event(input int len, input int gap, input logic d);
    int  nreq = 0;
    bit  dbl = 0, prev = 0, end_deep;
    bit  ok = style_ok(s_pulse, s_level);
    bit  exp_req = ok && (len >= DEB + 4);
    bit  exp_deep = ok && s_level && !d && (len >= HOLD + 20);
    dbg = d;
    line = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (req) begin nreq++; if (prev) dbl = 1; end
      prev = req;
      if (deep && d) check(0, "R7", deep, 0);
      if (deep && s_pulse && !s_level) check(0, "R6", deep, 0);
    end
    end_deep = deep;
    line = 1'b1;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      if (req) begin nreq++; if (prev) dbl = 1; end
      prev = req;
      if (i == SYNC) check(!deep, "R8", deep, 0);
    end
    dbg = 1'b0;
    if (len < DEB) check(nreq == 0, "R3", nreq, 0);
    else           check(nreq == int'(exp_req) && !dbl, "R4", nreq, exp_req);
    check(end_deep == exp_deep, "R5", end_deep, exp_deep);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_c0de;
    void'($urandom(seed));

    // directed: level style, strap change ignored, veto mid-low
    do_reset(1'b0, 1'b1, 1'b1);
    s_spi = 1'b0; s_pulse = 1'b1;
    repeat (3) @(negedge clk);
    check(props == exp_props(1'b0, 1'b1, 1'b1), "R1", props, exp_props(1'b0, 1'b1, 1'b1));
    s_spi = 1'b1; s_pulse = 1'b0;
    line = 1'b0;
    repeat (HOLD + 20) @(negedge clk);
    check(deep, "R5", deep, 1);
    dbg = 1'b1;
    #1;
    check(!deep, "R7", deep, 0);
    @(negedge clk); dbg = 1'b0;
    #1;
    check(deep, "R5", deep, 1);
    line = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    check(!deep, "R8", deep, 0);
    repeat (10) @(negedge clk);
    low_event(DEB - 1, 12, 1'b0);
    low_event(HOLD - 20, 12, 1'b0);

    // random lows under every strap combination
    for (int m = 0; m < 4; m++) begin
      do_reset(m[0], m[1], 1'($urandom_range(0, 1)));
      for (int k = 0; k < 10; k++) begin
        int kind = $urandom_range(0, 2);
        int len  = (kind == 0) ? $urandom_range(1, 2) :
                   (kind == 1) ? $urandom_range(8, 25) : $urandom_range(60, 90);
        logic d  = (kind == 2) && ($urandom_range(0, 3) == 0);
        low_event(len, $urandom_range(10, 20), d);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule